// File: doc/BRIEF.md
# Nibble Link Port

This block moves whole data words between two chips over four data wires, one strobe wire driven by the sender and one flow-control wire driven back by the receiver. A strap input places each instance in one of two modes. In send mode the core writes a word, and the word goes out one nibble per strobe transition, least significant nibble first. In receive mode the instance collects nibbles on every strobe transition and rebuilds the word for the core to read. The word length is 32 or 48 bits and is set by a second strap. Both ends must use the same word length.

Each direction has two stages. On the send side, a holding register takes the next word while the current word shifts out. On the receive side, a holding register keeps the last complete word while the assembly register takes the next one. The receiver raises its flow-control line only while it can accept a whole word. The sender starts a word only while it sees that line high, and it always finishes a word once it has started.

Both ends run from one core clock. The strobe changes at most once per core cycle, so the link carries one nibble per cycle.

Top module: `link_port`

## Requirements
- R1: Words leave the sender least significant nibble first. A word is 8 nibbles when `cfg_wide_i` is 0 and 12 nibbles when it is 1. Each nibble is placed on `lnk_dat_o` together with one transition of `lnk_clk_o`.
- R2: In send mode, every transition of `lnk_clk_o` carries exactly one nibble. A word therefore produces exactly 8 or 12 transitions of `lnk_clk_o`.
- R3: `lnk_clk_o` is 1 after reset, between words, and after the last nibble of every word.
- R4: The sender starts a word only when it sees `lnk_ack_i` high before the first transition. A word that has started runs to completion even if `lnk_ack_i` falls during the word.
- R5: In receive mode, `lnk_ack_o` is 1 exactly when the receive holding register is empty. In send mode, `lnk_ack_o` is always 0.
- R6: `rx_rdy_o` rises in the cycle after the last nibble of a word is captured, and `rx_data_o` then holds that word. A 32-bit word appears with bits 47:32 at zero. A read pulse on `rx_rd_i` while `rx_rdy_o` is 1 clears `rx_rdy_o` at the next clock.
- R7: `tx_free_o` is 1 when the send holding register is empty. A write on `tx_wr_i` while `tx_free_o` is 0 is dropped, and that word is never sent.
- R8: In receive mode, the send path ignores writes: `tx_free_o` stays 1 and `lnk_clk_o` stays 1.
- R9: The nibbles of one word go out on consecutive core cycles with no stall. Consecutive words are separated by at least one cycle in which `lnk_clk_o` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, shared by both ends |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_tx_i | input | 1 | 1 selects send mode, 0 selects receive mode |
| cfg_wide_i | input | 1 | 1 selects 48-bit words, 0 selects 32-bit words |
| tx_wr_i | input | 1 | Write strobe for the send holding register |
| tx_data_i | input | 48 | Word to send; bits 31:0 only when narrow |
| tx_free_o | output | 1 | Send holding register is empty |
| rx_rd_i | input | 1 | Read strobe; releases the received word |
| rx_data_o | output | 48 | Last received word |
| rx_rdy_o | output | 1 | A received word is waiting |
| lnk_clk_o | output | 1 | Outgoing strobe |
| lnk_dat_o | output | 4 | Outgoing nibble |
| lnk_ack_i | input | 1 | Flow control from the far receiver |
| lnk_clk_i | input | 1 | Incoming strobe |
| lnk_dat_i | input | 4 | Incoming nibble |
| lnk_ack_o | output | 1 | Flow control to the far sender |

## Verification
The bench uses the default parameters: 4-bit nibbles, a 48-bit word and a 32-bit narrow word. This gives both nibble counts, 8 and 12, and the zero-filled upper 16 bits of a narrow word. Two instances are wired back to back, one in each mode. The bench can also force the flow-control line low on its own. This lets it stall the sender with both holding registers full, and it lets it pull the acknowledge away while a word is in flight. These are the two places where a word could be lost, duplicated or cut short.

// File: rtl/lp_pkg.sv
package lp_pkg;
    localparam int unsigned LP_NIB_W    = 4;
    localparam int unsigned LP_WORD_W   = 48;
    localparam int unsigned LP_NARROW_W = 32;

    typedef enum logic {
        TX_IDLE = 1'b0,
        TX_SEND = 1'b1
    } tx_phase_e;
endpackage

// File: rtl/lp_tx.sv
module lp_tx
    import lp_pkg::*;
#(
    parameter int unsigned NIB_W    = LP_NIB_W,
    parameter int unsigned WORD_W   = LP_WORD_W,
    parameter int unsigned NARROW_W = LP_NARROW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              wide_i,
    input  logic              wr_i,
    input  logic [WORD_W-1:0] data_i,
    output logic              free_o,
    input  logic              ack_i,
    output logic              lclk_o,
    output logic [NIB_W-1:0]  ldat_o
);
    localparam int unsigned NIBS_WIDE   = WORD_W / NIB_W;
    localparam int unsigned NIBS_NARROW = NARROW_W / NIB_W;
    localparam int unsigned CNT_W       = $clog2(NIBS_WIDE);

    typedef struct packed {
        logic [WORD_W-1:0] hold;
        logic              hold_full;
        logic [WORD_W-1:0] sreg;
        logic [CNT_W-1:0]  cnt;
        tx_phase_e         phase;
        logic              lclk;
        logic [NIB_W-1:0]  ldat;
    } tx_state_t;

    tx_state_t q, d;
    logic      start;

    always_comb begin
        d     = q;
        start = en_i && (q.phase == TX_IDLE) && q.hold_full && ack_i;

        if (wr_i && en_i && !q.hold_full) begin
            d.hold      = data_i;
            d.hold_full = 1'b1;
        end

        case (q.phase)
            TX_IDLE: begin
                if (start) begin
                    d.hold_full = 1'b0;
                    d.ldat      = q.hold[NIB_W-1:0];
                    d.sreg      = q.hold >> NIB_W;
                    d.lclk      = ~q.lclk;
                    d.cnt       = wide_i ? CNT_W'(NIBS_WIDE - 1) : CNT_W'(NIBS_NARROW - 1);
                    d.phase     = TX_SEND;
                end
            end
            default: begin
                if (q.cnt != '0) begin
                    d.ldat = q.sreg[NIB_W-1:0];
                    d.sreg = q.sreg >> NIB_W;
                    d.lclk = ~q.lclk;
                    d.cnt  = q.cnt - 1'b1;
                end else begin
                    d.phase = TX_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.lclk <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign free_o = !q.hold_full;
    assign lclk_o = q.lclk;
    assign ldat_o = q.ldat;

    // R4
    start_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == TX_IDLE) ##1 (q.phase == TX_SEND) |-> $past(ack_i));

    // R4
    word_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == TX_SEND && q.cnt != '0) |=> (q.phase == TX_SEND && q.lclk != $past(q.lclk)));

    // R3
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == TX_IDLE) |-> q.lclk);

    // R7
    full_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && q.hold_full) |=> $stable(q.hold));
endmodule

// File: rtl/lp_rx.sv
module lp_rx
    import lp_pkg::*;
#(
    parameter int unsigned NIB_W    = LP_NIB_W,
    parameter int unsigned WORD_W   = LP_WORD_W,
    parameter int unsigned NARROW_W = LP_NARROW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              wide_i,
    input  logic              lclk_i,
    input  logic [NIB_W-1:0]  ldat_i,
    input  logic              rd_i,
    output logic [WORD_W-1:0] data_o,
    output logic              rdy_o,
    output logic              ack_o
);
    localparam int unsigned NIBS_WIDE   = WORD_W / NIB_W;
    localparam int unsigned NIBS_NARROW = NARROW_W / NIB_W;
    localparam int unsigned CNT_W       = $clog2(NIBS_WIDE);

    typedef struct packed {
        logic              prev;
        logic [WORD_W-1:0] asm_w;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] hold;
        logic              hold_full;
    } rx_state_t;

    rx_state_t         q, d;
    logic              cap, last, done;
    logic [WORD_W-1:0] merged;

    always_comb begin
        d      = q;
        d.prev = lclk_i;
        cap    = en_i && (lclk_i != q.prev);
        last   = (q.cnt == (wide_i ? CNT_W'(NIBS_WIDE - 1) : CNT_W'(NIBS_NARROW - 1)));
        done   = cap && last;

        merged = q.asm_w;
        for (int i = 0; i < NIBS_WIDE; i++) begin
            if (q.cnt == CNT_W'(i)) begin
                merged[i*NIB_W +: NIB_W] = ldat_i;
            end
        end

        if (rd_i && q.hold_full) begin
            d.hold_full = 1'b0;
        end

        if (cap) begin
            if (last) begin
                d.hold      = merged;
                d.hold_full = 1'b1;
                d.asm_w     = '0;
                d.cnt       = '0;
            end else begin
                d.asm_w = merged;
                d.cnt   = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.prev <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign data_o = q.hold;
    assign rdy_o  = q.hold_full;
    assign ack_o  = en_i && !q.hold_full;

    // R5
    ack_when_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.hold_full |-> !ack_o);

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && q.hold_full) |-> rd_i);

    // R6
    rdy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.hold_full && rd_i && !done) |=> !rdy_o);
endmodule

// File: rtl/link_port.sv
module link_port
    import lp_pkg::*;
#(
    parameter int unsigned NIB_W    = LP_NIB_W,
    parameter int unsigned WORD_W   = LP_WORD_W,
    parameter int unsigned NARROW_W = LP_NARROW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_tx_i,
    input  logic              cfg_wide_i,
    input  logic              tx_wr_i,
    input  logic [WORD_W-1:0] tx_data_i,
    output logic              tx_free_o,
    input  logic              rx_rd_i,
    output logic [WORD_W-1:0] rx_data_o,
    output logic              rx_rdy_o,
    output logic              lnk_clk_o,
    output logic [NIB_W-1:0]  lnk_dat_o,
    input  logic              lnk_ack_i,
    input  logic              lnk_clk_i,
    input  logic [NIB_W-1:0]  lnk_dat_i,
    output logic              lnk_ack_o
);
    lp_tx #(.NIB_W(NIB_W), .WORD_W(WORD_W), .NARROW_W(NARROW_W)) u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (cfg_tx_i),
        .wide_i (cfg_wide_i),
        .wr_i   (tx_wr_i),
        .data_i (tx_data_i),
        .free_o (tx_free_o),
        .ack_i  (lnk_ack_i),
        .lclk_o (lnk_clk_o),
        .ldat_o (lnk_dat_o)
    );

    lp_rx #(.NIB_W(NIB_W), .WORD_W(WORD_W), .NARROW_W(NARROW_W)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (!cfg_tx_i),
        .wide_i (cfg_wide_i),
        .lclk_i (lnk_clk_i),
        .ldat_i (lnk_dat_i),
        .rd_i   (rx_rd_i),
        .data_o (rx_data_o),
        .rdy_o  (rx_rdy_o),
        .ack_o  (lnk_ack_o)
    );
endmodule

// File: tb/link_port_bench.sv
module link_port_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wide = 1'b0;
    logic        tx_wr = 1'b0;
    logic [47:0] tx_data = '0;
    logic        rx_rd = 1'b0;
    logic        ack_en = 1'b1;
    logic        rxi_wr = 1'b0;

    logic        tx_free, tx_rdy_unused, tx_ack_o;
    logic [47:0] tx_rdata_unused;
    logic        lclk;
    logic [3:0]  ldat;
    logic        rxi_free, rx_rdy, rx_ack, rxi_lclk;
    logic [47:0] rx_data;
    logic [3:0]  rxi_ldat;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [47:0] exp_link[$];
    logic [47:0] exp_rx[$];

    always #10 clk = ~clk;

    link_port u_link_port (
        .clk(clk), .rst_n(rst_n), .cfg_tx_i(1'b1), .cfg_wide_i(wide),
        .tx_wr_i(tx_wr), .tx_data_i(tx_data), .tx_free_o(tx_free),
        .rx_rd_i(1'b0), .rx_data_o(tx_rdata_unused), .rx_rdy_o(tx_rdy_unused),
        .lnk_clk_o(lclk), .lnk_dat_o(ldat), .lnk_ack_i(rx_ack & ack_en),
        .lnk_clk_i(1'b1), .lnk_dat_i(4'h0), .lnk_ack_o(tx_ack_o)
    );

    link_port u_link_port_rx (
        .clk(clk), .rst_n(rst_n), .cfg_tx_i(1'b0), .cfg_wide_i(wide),
        .tx_wr_i(rxi_wr), .tx_data_i(48'hABCDEF012345), .tx_free_o(rxi_free),
        .rx_rd_i(rx_rd), .rx_data_o(rx_data), .rx_rdy_o(rx_rdy),
        .lnk_clk_o(rxi_lclk), .lnk_dat_o(rxi_ldat), .lnk_ack_i(1'b1),
        .lnk_clk_i(lclk), .lnk_dat_i(ldat), .lnk_ack_o(rx_ack)
    );

    function automatic logic [47:0] exp_word(input logic [47:0] v, input logic w);
        return w ? v : {16'h0, v[31:0]};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // independent link monitor: R1, R2, R3, R9
    bit          prev_clk = 1'b1;
    bit          in_word = 1'b0;
    int          nib = 0;
    int          idle = 1;
    logic [47:0] acc = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (in_word) begin
                if (lclk != prev_clk) begin
                    acc[nib*4 +: 4] = ldat;
                    nib++;
                    if (nib == (wide ? 12 : 8)) begin
                        in_word = 1'b0;
                        idle = 0;
                        if (exp_link.size() > 0) begin
                            chk(acc == exp_link[0], "R1 nibble order/count", acc, exp_link[0]);
                            void'(exp_link.pop_front());
                        end else begin
                            chk(1'b0, "R2 unexpected word on link", acc, 48'h0);
                        end
                        chk(lclk == 1'b1, "R3 strobe high after word", 48'(lclk), 48'h1);
                    end
                end else begin
                    chk(1'b0, "R9 stall inside word", 48'(nib), 48'(wide ? 12 : 8));
                end
            end else if (lclk != prev_clk) begin
                chk(idle >= 1, "R9 gap between words", 48'(idle), 48'h1);
                in_word = 1'b1;
                acc = '0;
                acc[3:0] = ldat;
                nib = 1;
            end else begin
                idle++;
            end
        end
        prev_clk = lclk;
    end

    task automatic push_word(input logic [47:0] v);
        int t = 0;
        @(negedge clk);
        while (!tx_free && t < 2000) begin
            @(negedge clk);
            t++;
        end
        tx_wr = 1'b1;
        tx_data = v;
        exp_link.push_back(exp_word(v, wide));
        exp_rx.push_back(exp_word(v, wide));
        @(negedge clk);
        tx_wr = 1'b0;
    endtask

    task automatic read_check(input string tag);
        int t = 0;
        @(negedge clk);
        while (!rx_rdy && t < 2000) begin
            @(negedge clk);
            t++;
        end
        if (exp_rx.size() > 0) begin
            chk(rx_rdy && rx_data == exp_rx[0], tag, rx_data, exp_rx[0]);
            void'(exp_rx.pop_front());
        end
        rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
        chk(!rx_rdy, "R6 ready clears after read", 48'(rx_rdy), 48'h0);
    endtask

    task automatic run_batch(input int n, input logic w);
        int issued = 0;
        int got = 0;
        int cyc = 0;
        logic [63:0] r;
        wide = w;
        while (got < n && cyc < 20000) begin
            @(negedge clk);
            tx_wr = 1'b0;
            rx_rd = 1'b0;
            if (rx_rdy && $urandom_range(3) == 0) begin
                if (exp_rx.size() > 0) begin
                    chk(rx_data == exp_rx[0], "R6 random word", rx_data, exp_rx[0]);
                    void'(exp_rx.pop_front());
                end
                rx_rd = 1'b1;
                got++;
            end
            if (issued < n && tx_free && $urandom_range(2) != 0) begin
                r = {$urandom(), $urandom()};
                tx_wr = 1'b1;
                tx_data = r[47:0];
                exp_link.push_back(exp_word(r[47:0], w));
                exp_rx.push_back(exp_word(r[47:0], w));
                issued++;
            end
            cyc++;
        end
        @(negedge clk);
        tx_wr = 1'b0;
        rx_rd = 1'b0;
        repeat (4) @(negedge clk);
        chk(got == n, "R6 batch delivered", 48'(got), 48'(n));
    endtask

    initial begin
        bit stayed;
        void'($urandom(32'd20240517));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        chk(lclk == 1'b1, "R3 strobe high after reset", 48'(lclk), 48'h1);
        chk(tx_free == 1'b1, "R7 send holding empty after reset", 48'(tx_free), 48'h1);
        chk(rx_ack == 1'b1, "R5 receiver ack after reset", 48'(rx_ack), 48'h1);
        chk(tx_ack_o == 1'b0, "R5 sender-mode ack low", 48'(tx_ack_o), 48'h0);
        chk(rx_rdy == 1'b0, "R6 not ready after reset", 48'(rx_rdy), 48'h0);

        // directed narrow and wide words
        wide = 1'b0;
        push_word(48'hFFFF_8765_4321);
        read_check("R6 narrow word zero-extended");
        wide = 1'b1;
        push_word(48'h0123_4567_89AB);
        read_check("R6 wide word");

        // backpressure with both holding registers full: R4, R5, R7
        wide = 1'b0;
        push_word(48'h0000_1111_2222);
        push_word(48'h0000_3333_4444);
        repeat (30) @(negedge clk);
        chk(rx_rdy && !rx_ack, "R5 ack low while holding full", 48'(rx_ack), 48'h0);
        chk(!tx_free, "R7 send holding occupied", 48'(tx_free), 48'h0);
        tx_wr = 1'b1;
        tx_data = 48'h0000_DEAD_BEEF;
        @(negedge clk);
        tx_wr = 1'b0;
        stayed = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (lclk != 1'b1) stayed = 1'b0;
        end
        chk(stayed, "R4 no start without ack", 48'(stayed), 48'h1);
        read_check("R4 first stalled word");
        read_check("R4 second stalled word");
        stayed = 1'b1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (rx_rdy || lclk != 1'b1) stayed = 1'b0;
        end
        chk(stayed, "R7 write while full dropped", 48'(stayed), 48'h1);

        // ack withdrawn mid-word: R4
        wide = 1'b1;
        push_word(48'hC0FF_EE12_3456);
        while (lclk == 1'b1) @(negedge clk);
        repeat (2) @(negedge clk);
        ack_en = 1'b0;
        read_check("R4 word completes after ack drop");
        ack_en = 1'b1;

        // receive-mode instance ignores writes: R8
        @(negedge clk);
        rxi_wr = 1'b1;
        @(negedge clk);
        rxi_wr = 1'b0;
        stayed = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (rxi_lclk != 1'b1 || rxi_free != 1'b1) stayed = 1'b0;
        end
        chk(stayed, "R8 receive mode send path inert", 48'(stayed), 48'h1);

        // random traffic: R1, R2, R6, R9
        run_batch(30, 1'b0);
        run_batch(30, 1'b1);
        run_batch(20, 1'b0);
        chk(exp_link.size() == 0, "R2 all link words seen", 48'(exp_link.size()), 48'h0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule